// File: doc/BRIEF.md
# Multi-Cycle Restoring Integer Divider

This block divides one integer by another over several clock cycles. A request carries a dividend, a divisor and a flag that selects two's-complement or unsigned treatment. The answer comes back as a remainder word (`rsp_hi`) and a quotient word (`rsp_lo`). Inside, one register of twice the operand width holds the partial remainder in its upper part and collects quotient bits in its lower part. A single subtractor is shared across all iterations. Each cycle the subtractor tries the divisor against the upper part, and a multiplexer keeps either the difference or the old value. A shift then moves in the new quotient bit. Because the register shifts once before the loop, the remainder ends up one position too far left. The output therefore reads the upper part shifted back right by one.

Signed requests are converted to magnitudes when they are accepted. The signs are applied again at the output. A zero divisor is not an error: the loop runs as usual, the result is well defined, and `rsp_div_zero` marks it.

Requests enter over a valid/ready handshake and results leave over another. The block holds one operation at a time. `req_ready` stays low from acceptance until the result has been taken. A result is held steady while `rsp_ready` is low, so back-pressure on the result side stalls new requests.

Top module: `restoring_divider`

## Requirements
- R1: `req_ready` is high only while no operation is in flight or waiting to be taken; `busy` is its complement; a request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- R2: `rsp_valid` first reads high after the WIDTH-th rising edge that follows the accepting edge.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_hi`, `rsp_lo` and `rsp_div_zero` hold their values; the edge with both high ends the response and the block becomes ready.
- R4: With `req_signed` = 0 and a non-zero divisor, `rsp_lo` is the unsigned floor quotient and `rsp_hi` the unsigned remainder.
- R5: With `req_signed` = 1, the quotient rounds toward zero and the remainder carries the sign of the dividend (-7 / 2 gives `rsp_lo` = -3, `rsp_hi` = -1; 7 / -2 gives -3 and 1).
- R6: For a non-zero divisor, `rsp_lo` × divisor + `rsp_hi` equals the dividend modulo 2^WIDTH, and the magnitude of `rsp_hi` is below the magnitude of the divisor.
- R7: Signed most-negative dividend divided by -1 gives `rsp_lo` = the most-negative value and `rsp_hi` = 0.
- R8: A zero divisor sets `rsp_div_zero` = 1 and gives `rsp_hi` = dividend. `rsp_lo` is all ones when unsigned. When signed, `rsp_lo` is -1 for a non-negative dividend and +1 for a negative one. For any non-zero divisor `rsp_div_zero` = 0.
- R9: After reset `req_ready` = 1, `busy` = 0 and `rsp_valid` = 0.
- R10: A request presented while an operation is in flight is not taken and does not change the result of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_dividend | input | WIDTH | Dividend |
| req_divisor | input | WIDTH | Divisor |
| req_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | An operation is in flight or its result is waiting |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hi | output | WIDTH | Remainder |
| rsp_lo | output | WIDTH | Quotient |
| rsp_div_zero | output | 1 | Result came from a zero divisor |

## Verification
The bench instantiates the block at its default WIDTH of 32. This makes the full-width corner cases reachable: the most-negative dividend, divisors at or above 2^31 in unsigned mode (where the partial remainder needs the extra guard bit), and all-ones operands. A reference model computes the quotient and remainder independently for random signed and unsigned pairs. Separate directed runs hold `rsp_ready` low to exercise stalls on the result side, and offer competing requests while the block is busy.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_operand_prep.sv
// Turns raw operands into magnitudes and records how the result signs must be fixed.
module rdiv_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             is_signed,
  output logic [WIDTH-1:0] mag_dividend,
  output logic [WIDTH-1:0] mag_divisor,
  output logic             neg_quo,
  output logic             neg_rem,
  output logic             dvs_zero
);
  logic sgn_a, sgn_b;

  assign sgn_a        = is_signed & dividend[WIDTH-1];
  assign sgn_b        = is_signed & divisor[WIDTH-1];
  assign mag_dividend = sgn_a ? (~dividend + 1'b1) : dividend;
  assign mag_divisor  = sgn_b ? (~divisor + 1'b1) : divisor;
  assign neg_rem      = sgn_a;
  assign neg_quo      = sgn_a ^ sgn_b;
  assign dvs_zero     = (divisor == '0);
endmodule

// File: rtl/rdiv_step.sv
// One restoring iteration: trial subtract, keep or restore, shift in quotient bit.
module rdiv_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   hi_cur,
  input  logic [WIDTH-1:0] lo_cur,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH:0]   hi_nxt,
  output logic [WIDTH-1:0] lo_nxt
);
  localparam int DW = WIDTH + 2;

  logic [DW-1:0] diff;
  logic          fits;
  logic [WIDTH:0] keep;
  logic          unused_keep_top;

  assign diff = {1'b0, hi_cur} - {2'b00, dvs};
  assign fits = ~diff[DW-1];
  // restore is a select, so one iteration costs one cycle
  assign keep = fits ? diff[WIDTH:0] : hi_cur;
  // kept value is below the divisor, so its top bit is always zero
  assign unused_keep_top = keep[WIDTH];
  assign hi_nxt = {keep[WIDTH-1:0], lo_cur[WIDTH-1]};
  assign lo_nxt = {lo_cur[WIDTH-2:0], fits};
endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_mag,
  input  logic [WIDTH-1:0] quo_mag,
  input  logic             neg_rem,
  input  logic             neg_quo,
  output logic [WIDTH-1:0] rem_out,
  output logic [WIDTH-1:0] quo_out
);
  assign rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
  assign quo_out = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] req_dividend,
  input  logic [WIDTH-1:0] req_divisor,
  input  logic             req_signed,
  output logic             busy,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_hi,
  output logic [WIDTH-1:0] rsp_lo,
  output logic             rsp_div_zero
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  rdiv_state_e     state_q;
  logic [CW-1:0]   iter_q;
  logic [WIDTH:0]  hi_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH-1:0] dvs_q;
  logic            neg_quo_q, neg_rem_q, zero_q;

  logic [WIDTH-1:0] mag_a, mag_b;
  logic            p_neg_quo, p_neg_rem, p_zero;
  logic [WIDTH:0]  hi_nx;
  logic [WIDTH-1:0] lo_nx;
  logic            take_req;

  rdiv_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .dividend     (req_dividend),
    .divisor      (req_divisor),
    .is_signed    (req_signed),
    .mag_dividend (mag_a),
    .mag_divisor  (mag_b),
    .neg_quo      (p_neg_quo),
    .neg_rem      (p_neg_rem),
    .dvs_zero     (p_zero)
  );

  rdiv_step #(.WIDTH(WIDTH)) u_step (
    .hi_cur (hi_q),
    .lo_cur (lo_q),
    .dvs    (dvs_q),
    .hi_nxt (hi_nx),
    .lo_nxt (lo_nx)
  );

  // upper part is one place too far left after the loop: read it shifted back
  rdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .rem_mag (hi_q[WIDTH:1]),
    .quo_mag (lo_q),
    .neg_rem (neg_rem_q),
    .neg_quo (neg_quo_q),
    .rem_out (rsp_hi),
    .quo_out (rsp_lo)
  );

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign rsp_valid    = (state_q == ST_DONE);
  assign rsp_div_zero = zero_q;
  assign take_req     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      iter_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zero_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_req) begin
            // load dividend into the lower part with the pre-loop shift folded in
            hi_q      <= {{WIDTH{1'b0}}, mag_a[WIDTH-1]};
            lo_q      <= {mag_a[WIDTH-2:0], 1'b0};
            dvs_q     <= mag_b;
            neg_quo_q <= p_neg_quo;
            neg_rem_q <= p_neg_rem;
            zero_q    <= p_zero;
            iter_q    <= '0;
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          hi_q   <= hi_nx;
          lo_q   <= lo_nx;
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [WIDTH-1:0] req_dividend,
  input logic [WIDTH-1:0] req_divisor,
  input logic             req_signed,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [WIDTH-1:0] rsp_hi,
  input logic [WIDTH-1:0] rsp_lo,
  input logic             rsp_div_zero
);
  logic [WIDTH-1:0] cap_a, cap_b;
  logic             cap_s;
  int unsigned      lat;
  logic [WIDTH-1:0] recon;

  function automatic logic [WIDTH-1:0] magof(input logic [WIDTH-1:0] v, input logic s);
    return (s && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
      lat   <= 0;
    end else if (req_valid && req_ready) begin
      cap_a <= req_dividend;
      cap_b <= req_divisor;
      cap_s <= req_signed;
      lat   <= 0;
    end else if (busy && !rsp_valid) begin
      lat <= lat + 1;
    end
  end

  assign recon = rsp_lo * cap_b + rsp_hi;

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat == WIDTH)); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hi) && $stable(rsp_lo) && $stable(rsp_div_zero))); // R3
  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (recon == cap_a)); // R6
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cap_b != '0) |-> (magof(rsp_hi, cap_s) < magof(cap_b, cap_s))); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_div_zero == (cap_b == '0))); // R8
endmodule

bind restoring_divider rdiv_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/restoring_divider_tb.sv
`timescale 1ns/1ps
module restoring_divider_tb;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a, b, hi, lo;
    logic s, z;
    int acc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_signed = 1'b0;
  logic [W-1:0] req_dividend = '0, req_divisor = '0;
  logic busy, rsp_valid, rsp_ready = 1'b1, rsp_div_zero;
  logic [W-1:0] rsp_hi, rsp_lo;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit stall_en = 1'b0, finished = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  restoring_divider #(.WIDTH(W)) u_dut (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic s, string req);
    exp_t e;
    longint sa, sb2, q, r;
    e.a = a; e.b = b; e.s = s; e.req = req; e.acc = 0;
    e.z = (b == '0);
    if (b == '0) begin // R8 defined result
      e.hi = a;
      e.lo = (s && a[W-1]) ? W'(1) : '1;
    end else if (s) begin
      sa = longint'($signed(a)); sb2 = longint'($signed(b));
      q = sa / sb2; r = sa % sb2;
      e.lo = q[W-1:0]; e.hi = r[W-1:0];
    end else begin
      e.lo = a / b; e.hi = a % b;
    end
    return e;
  endfunction

  // driver: push expectation, present request, wait for the scoreboard to drain
  task automatic run(logic [W-1:0] a, logic [W-1:0] b, logic s, string req, bit intrude = 1'b0);
    exp_t e;
    e = model(a, b, s, req);
    @(negedge clk);
    req_dividend = a; req_divisor = b; req_signed = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e.acc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    if (intrude) begin // R10: competing request while busy
      req_dividend = 32'h1234_5678; req_divisor = 32'd3; req_signed = ~s;
      for (int k = 0; k < 6; k++) begin
        chk("R1", {31'b0, req_ready}, 32'd0, "ready while busy");
        chk("R1", {31'b0, busy}, 32'd1, "busy in flight");
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: compare results as they appear
  initial begin
    bit seen = 1'b0;
    int held = 0;
    logic [W-1:0] snap_hi, snap_lo;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid && sb.size() != 0) begin
        e = sb[0];
        if (!seen) begin
          seen = 1'b1; held = 0;
          chk("R2", W'(cyc), W'(e.acc + W), "latency");
        end else if (held > 0) begin
          chk("R3", rsp_hi, snap_hi, "hi held");
          chk("R3", rsp_lo, snap_lo, "lo held");
        end
        snap_hi = rsp_hi; snap_lo = rsp_lo;
        if (stall_en && held < 2) begin
          rsp_ready = 1'b0; held++;
        end else begin
          rsp_ready = 1'b1;
          chk(e.req, rsp_hi, e.hi, "remainder");
          chk(e.req, rsp_lo, e.lo, "quotient");
          chk("R8", {31'b0, rsp_div_zero}, {31'b0, e.z}, "zero flag");
          if (e.b != '0) begin
            chk("R6", W'(rsp_lo * e.b + rsp_hi), e.a, "identity");
            if (e.s)
              chk("R6", {31'b0, ((rsp_hi[W-1] ? -rsp_hi : rsp_hi) < (e.b[W-1] ? -e.b : e.b))}, 32'd1, "bound");
            else
              chk("R6", {31'b0, (rsp_hi < e.b)}, 32'd1, "bound");
          end
          void'(sb.pop_front());
          seen = 1'b0;
        end
      end else if (!rsp_valid) begin
        rsp_ready = !stall_en;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", {31'b0, req_ready}, 32'd1, "ready in reset");
    chk("R9", {31'b0, busy}, 32'd0, "busy in reset");
    chk("R9", {31'b0, rsp_valid}, 32'd0, "valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", {31'b0, req_ready}, 32'd1, "ready after reset");

    run(32'd100, 32'd7, 1'b0, "R4");
    run(32'hFFFF_FFFF, 32'd1, 1'b0, "R4");
    run(32'd5, 32'hFFFF_FFFF, 1'b0, "R4");
    run(32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R4");
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R4");
    run(32'd0, 32'd3, 1'b0, "R4");
    run(-32'sd7, 32'sd2, 1'b1, "R5");
    run(32'sd7, -32'sd2, 1'b1, "R5");
    run(-32'sd7, -32'sd2, 1'b1, "R5");
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7");
    run(32'h8000_0000, 32'd1, 1'b1, "R7");
    run(32'd123, 32'd0, 1'b0, "R8");
    run(-32'sd5, 32'd0, 1'b1, "R8");
    run(32'sd5, 32'd0, 1'b1, "R8");
    run(32'd1000, 32'd9, 1'b0, "R10", 1'b1);
    run(-32'sd1000, 32'sd9, 1'b1, "R10", 1'b1);
    stall_en = 1'b1;
    run(32'd77, 32'd5, 1'b0, "R3");
    run(-32'sd77, 32'sd5, 1'b1, "R3");
    stall_en = 1'b0;
    @(negedge clk);
    chk("R3", {31'b0, req_ready}, 32'd1, "ready after taken");
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? ($urandom >> ($urandom % 31)) : $urandom;
      stall_en = (i % 7 == 0);
      run(a, b, i[0], i[0] ? "R5" : "R4");
    end
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule